// File: doc/BRIEF.md
# TLB Maintenance Register Interface

This block is the special-register front end that a processor core uses to maintain its translation lookaside buffer. It holds three registers: an entry index, a process ID and a zone protection word. It also holds the TLB entry storage: for every entry a 32-bit tag word, a 64-bit data word and an 8-bit translation ID. Register accesses arrive as single-cycle requests. A read returns its data combinationally in the same cycle. A write takes effect at the next rising clock edge.

Accesses to the tag word (HI) and the data word (LO) act on the entry that the low bits of the index register select. Two of these accesses have side effects. Writing HI also records the current process ID as that entry's translation ID. Reading HI loads the process ID register from the entry's translation ID. A write to the search register runs an associative lookup on the page-number part of the written address. The lookup puts the matching entry number into the index register, or sets the read-only miss flag in bit 31 when no entry matches. The extended access flag selects the upper half of the data word and is legal only on LO.

Any access the configuration forbids raises `acc_err` in the same cycle. Such a read returns zero and such a write changes no state. The parameter `TLB_MODE` selects the configuration: 0 means no TLB-capable unit, 1 means limited access, 2 means full access.

Top module: `tlb_maint_if`

## Requirements
- R1: After reset the process ID, zone and index registers read 0, and every entry is invalid, so a search misses.
- R2: HI and LO accesses act on entry `index[IDX_W-1:0]`, where IDX_W = log2(NUM_ENTRIES). The other index bits are ignored.
- R3: Writing HI (select 3) stores the write data as the tag word and stores the 8-bit process ID as that entry's translation ID. The process ID register (select 0) keeps only write-data bits 7:0 and reads back zero-extended.
- R4: Reading HI returns the tag word and loads the process ID register with that entry's translation ID.
- R5: Bit 31 of the index register (select 2) is a read-only miss flag. A write changes only bits 30:0.
- R6: Writing the search register (select 5) with address A sets the index register to the lowest-numbered matching entry, with bit 31 clear. An entry matches when tag bit 6 (valid) is 1 and A equals tag bits 31:10 in every bit above the page size.
- R7: A search with no matching entry sets the index register to 0x8000_0000.
- R8: Tag bits 9:7 hold a size code c, and the page size is 2^(10+2c) bytes. Address bits below that size are not compared.
- R9: An entry with translation ID 0 matches any process ID. An entry with a nonzero translation ID matches only when the process ID equals it.
- R10: With `acc_ext`=1, an access to LO (select 4) reads or writes data-word bits 63:32. With `acc_ext`=0 it uses bits 31:0. An extended access to any other register is illegal.
- R11: A read of the search register is illegal.
- R12: With TLB_MODE=1, writes to the process ID, zone and search registers are illegal. With TLB_MODE=0, every access is illegal.
- R13: Selects 6 and 7 are illegal. Any illegal access raises `acc_err`, a read returns 0, and a write leaves all registers and entries unchanged.
- R14: The zone register (select 1) stores and returns all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Register access request this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_ext | input | 1 | Extended (upper-half) access |
| acc_sel | input | 3 | Register select: 0 PID, 1 zone, 2 index, 3 HI, 4 LO, 5 search |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, valid in the request cycle |
| acc_err | output | 1 | Access rejected as illegal |

## Verification
The bound checker enforces several rules on every cycle:
- an illegal read returns zero and an illegal write holds the process ID, zone and index registers steady;
- a legal index write never alters the miss flag;
- an HI read transfers the selected translation ID into the process ID register, and an HI write records the process ID as the entry's translation ID;
- every search leaves the index register holding either the lookup's entry number or the exact miss code.

Only the bench scenarios can show that the lookup itself is correct. These scenarios cover page-size masking, the translation-ID rule, lowest-index priority when entries overlap, the 64-bit data-word halves, and the rejection rules of the limited and absent configurations.

// File: rtl/tlb_maint_pkg.sv
package tlb_maint_pkg;

  typedef enum logic [2:0] {
    SEL_PID    = 3'd0,
    SEL_ZONE   = 3'd1,
    SEL_INDEX  = 3'd2,
    SEL_HI     = 3'd3,
    SEL_LO     = 3'd4,
    SEL_SEARCH = 3'd5
  } reg_sel_e;

  localparam int unsigned TAG_VALID_BIT = 6;
  localparam int unsigned TAG_SIZE_LSB  = 7;
  localparam int unsigned PAGE_LSB      = 10;

  // Compare mask for a page of 2^(10+2*code) bytes.
  function automatic logic [31:0] size_mask(input logic [2:0] code);
    logic [4:0] sh;
    sh = 5'd10 + {1'b0, code, 1'b0};
    return 32'hFFFF_FFFF << sh;
  endfunction

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
  parameter int unsigned NUM_ENTRIES = 16,
  localparam int unsigned IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hi,
  input  logic             wr_lo,
  input  logic             wr_ext,
  input  logic [IDX_W-1:0] sel_idx,
  input  logic [31:0]      wdata,
  input  logic [7:0]       wtid,
  output logic [31:0]      sel_hi,
  output logic [63:0]      sel_lo,
  output logic [7:0]       sel_tid,
  output logic [31:0]      hi_all  [NUM_ENTRIES],
  output logic [7:0]       tid_all [NUM_ENTRIES]
);

  logic [63:0] lo_all [NUM_ENTRIES];

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    logic        hi_en;
    logic        lo_en;
    logic [63:0] lo_d;

    always_comb begin
      hi_en = wr_hi && (sel_idx == IDX_W'(g));
      lo_en = wr_lo && (sel_idx == IDX_W'(g));
      lo_d  = wr_ext ? {wdata, lo_all[g][31:0]} : {lo_all[g][63:32], wdata};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_all[g]  <= '0;
        tid_all[g] <= '0;
        lo_all[g]  <= '0;
      end else begin
        if (hi_en) begin
          hi_all[g]  <= wdata;
          tid_all[g] <= wtid;
        end
        if (lo_en) begin
          lo_all[g] <= lo_d;
        end
      end
    end
  end

  always_comb begin
    sel_hi  = hi_all[sel_idx];
    sel_lo  = lo_all[sel_idx];
    sel_tid = tid_all[sel_idx];
  end

endmodule

// File: rtl/tlb_search.sv
module tlb_search
  import tlb_maint_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 16,
  localparam int unsigned IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic [31:0]      va,
  input  logic [7:0]       pid,
  input  logic [31:0]      hi_all  [NUM_ENTRIES],
  input  logic [7:0]       tid_all [NUM_ENTRIES],
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx
);

  logic [NUM_ENTRIES-1:0] match;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
    logic [31:0] msk;
    logic        tid_ok;
    always_comb begin
      msk      = size_mask(hi_all[g][TAG_SIZE_LSB +: 3]);
      tid_ok   = (tid_all[g] == 8'd0) || (tid_all[g] == pid);
      match[g] = hi_all[g][TAG_VALID_BIT] && tid_ok &&
                 (((va ^ hi_all[g]) & msk) == 32'd0);
    end
  end

  // Lowest-numbered matching entry wins.
  always_comb begin
    hit     = |match;
    hit_idx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/tlb_maint_if.sv
module tlb_maint_if
  import tlb_maint_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 16,
  parameter int unsigned TLB_MODE    = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_en,
  input  logic        acc_wr,
  input  logic        acc_ext,
  input  logic [2:0]  acc_sel,
  input  logic [31:0] acc_wdata,
  output logic [31:0] acc_rdata,
  output logic        acc_err
);

  localparam int unsigned IDX_W = $clog2(NUM_ENTRIES);

  logic [7:0]       pid_q,   pid_d;
  logic [31:0]      zone_q,  zone_d;
  logic [31:0]      index_q, index_d;
  logic             pid_en, zone_en, index_en;
  logic             bad, ok_rd, ok_wr;
  logic             wr_hi, wr_lo, srch_go;
  logic [31:0]      ent_hi;
  logic [63:0]      ent_lo;
  logic [7:0]       ent_tid;
  logic [31:0]      hi_all  [NUM_ENTRIES];
  logic [7:0]       tid_all [NUM_ENTRIES];
  logic [31:0]      srch_va;
  logic             srch_hit;
  logic [IDX_W-1:0] srch_idx;

  // Legality decode
  always_comb begin
    bad = 1'b0;
    if (TLB_MODE == 0)                                  bad = 1'b1;
    if (acc_sel > SEL_SEARCH)                           bad = 1'b1;
    if (acc_ext && (acc_sel != SEL_LO))                 bad = 1'b1;
    if (!acc_wr && (acc_sel == SEL_SEARCH))             bad = 1'b1;
    if (acc_wr && (TLB_MODE < 2) &&
        ((acc_sel == SEL_PID) || (acc_sel == SEL_ZONE) ||
         (acc_sel == SEL_SEARCH)))                      bad = 1'b1;
    acc_err = acc_en && bad;
    ok_rd   = acc_en && !bad && !acc_wr;
    ok_wr   = acc_en && !bad && acc_wr;
    wr_hi   = ok_wr && (acc_sel == SEL_HI);
    wr_lo   = ok_wr && (acc_sel == SEL_LO);
    srch_go = ok_wr && (acc_sel == SEL_SEARCH);
    srch_va = {acc_wdata[31:PAGE_LSB], {PAGE_LSB{1'b0}}};
  end

  tlb_entry_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_hi   (wr_hi),
    .wr_lo   (wr_lo),
    .wr_ext  (acc_ext),
    .sel_idx (index_q[IDX_W-1:0]),
    .wdata   (acc_wdata),
    .wtid    (pid_q),
    .sel_hi  (ent_hi),
    .sel_lo  (ent_lo),
    .sel_tid (ent_tid),
    .hi_all  (hi_all),
    .tid_all (tid_all)
  );

  tlb_search #(.NUM_ENTRIES(NUM_ENTRIES)) u_search (
    .va      (srch_va),
    .pid     (pid_q),
    .hi_all  (hi_all),
    .tid_all (tid_all),
    .hit     (srch_hit),
    .hit_idx (srch_idx)
  );

  // Next-state logic for the registers
  always_comb begin
    pid_en   = 1'b0;
    pid_d    = pid_q;
    zone_en  = ok_wr && (acc_sel == SEL_ZONE);
    zone_d   = acc_wdata;
    index_en = 1'b0;
    index_d  = index_q;
    if (ok_wr && (acc_sel == SEL_PID)) begin
      pid_en = 1'b1;
      pid_d  = acc_wdata[7:0];
    end else if (ok_rd && (acc_sel == SEL_HI)) begin
      pid_en = 1'b1;
      pid_d  = ent_tid;
    end
    if (ok_wr && (acc_sel == SEL_INDEX)) begin
      index_en = 1'b1;
      index_d  = {index_q[31], acc_wdata[30:0]};
    end else if (srch_go) begin
      index_en = 1'b1;
      index_d  = srch_hit ? {1'b0, 31'(srch_idx)} : 32'h8000_0000;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pid_q   <= '0;
      zone_q  <= '0;
      index_q <= '0;
    end else begin
      if (pid_en)   pid_q   <= pid_d;
      if (zone_en)  zone_q  <= zone_d;
      if (index_en) index_q <= index_d;
    end
  end

  // Read mux
  always_comb begin
    acc_rdata = '0;
    if (ok_rd) begin
      case (acc_sel)
        SEL_PID:   acc_rdata = {24'd0, pid_q};
        SEL_ZONE:  acc_rdata = zone_q;
        SEL_INDEX: acc_rdata = index_q;
        SEL_HI:    acc_rdata = ent_hi;
        SEL_LO:    acc_rdata = acc_ext ? ent_lo[63:32] : ent_lo[31:0];
        default:   acc_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/tlb_maint_chk.sv
module tlb_maint_chk #(
  parameter int unsigned IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_en,
  input logic             acc_wr,
  input logic [2:0]       acc_sel,
  input logic             acc_err,
  input logic [31:0]      acc_rdata,
  input logic [7:0]       pid_q,
  input logic [31:0]      zone_q,
  input logic [31:0]      index_q,
  input logic [7:0]       ent_tid,
  input logic             srch_hit,
  input logic [IDX_W-1:0] srch_idx
);

  logic ok;
  assign ok = acc_en && !acc_err;

  // R3: an HI write records the process ID as the entry's translation ID
  p_hi_wr_tid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && acc_wr && acc_sel == 3'd3) |=> (ent_tid == $past(pid_q)));

  // R4: an HI read moves the selected translation ID into the process ID
  p_hi_rd_pid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && !acc_wr && acc_sel == 3'd3) |=> (pid_q == $past(ent_tid)));

  // R5: software index writes leave the miss flag alone
  p_index_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && acc_wr && acc_sel == 3'd2) |=> (index_q[31] == $past(index_q[31])));

  // R6: a hitting search loads the lookup's entry number
  p_search_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && acc_wr && acc_sel == 3'd5 && srch_hit) |=>
      (index_q == {1'b0, 31'($past(srch_idx))}));

  // R7: a missing search loads the miss code
  p_search_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && acc_wr && acc_sel == 3'd5 && !srch_hit) |=> (index_q == 32'h8000_0000));

  // R13: illegal reads return zero
  p_bad_rd_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_err && !acc_wr) |-> (acc_rdata == 32'd0));

  // R13: illegal writes change no register
  p_bad_wr_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_err && acc_wr) |=>
      ($stable(pid_q) && $stable(zone_q) && $stable(index_q)));

endmodule

bind tlb_maint_if tlb_maint_chk #(.IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_en    (acc_en),
  .acc_wr    (acc_wr),
  .acc_sel   (acc_sel),
  .acc_err   (acc_err),
  .acc_rdata (acc_rdata),
  .pid_q     (pid_q),
  .zone_q    (zone_q),
  .index_q   (index_q),
  .ent_tid   (ent_tid),
  .srch_hit  (srch_hit),
  .srch_idx  (srch_idx)
);

// File: tb/tb_tlb_maint_if.sv
module tb_tlb_maint_if;

  localparam time TCLK = 20ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        en_f, en_l, en_n;
  logic        wr_i, ext_i;
  logic [2:0]  sel_i;
  logic [31:0] wd_i;
  logic [31:0] rd_f, rd_l, rd_n;
  logic        err_f, err_l, err_n;

  int tests = 0;
  int fails = 0;
  bit pend  = 1'b0;
  bit done  = 1'b0;

  typedef struct {
    int          tgt;
    logic [31:0] exp_d;
    bit          exp_e;
    bit          chk_d;
    string       tag;
  } item_t;
  item_t sb[$];

  always #(TCLK/2) clk = ~clk;

  tlb_maint_if #(.NUM_ENTRIES(16), .TLB_MODE(2)) dut (
    .clk(clk), .rst_n(rst_n), .acc_en(en_f), .acc_wr(wr_i), .acc_ext(ext_i),
    .acc_sel(sel_i), .acc_wdata(wd_i), .acc_rdata(rd_f), .acc_err(err_f));

  tlb_maint_if #(.NUM_ENTRIES(16), .TLB_MODE(1)) dut_lim (
    .clk(clk), .rst_n(rst_n), .acc_en(en_l), .acc_wr(wr_i), .acc_ext(ext_i),
    .acc_sel(sel_i), .acc_wdata(wd_i), .acc_rdata(rd_l), .acc_err(err_l));

  tlb_maint_if #(.NUM_ENTRIES(16), .TLB_MODE(0)) dut_none (
    .clk(clk), .rst_n(rst_n), .acc_en(en_n), .acc_wr(wr_i), .acc_ext(ext_i),
    .acc_sel(sel_i), .acc_wdata(wd_i), .acc_rdata(rd_n), .acc_err(err_n));

  // Driver: one access per cycle, expectation pushed to the scoreboard
  task automatic acc(input int tgt, input bit wr, input bit ext, input logic [2:0] sel,
                     input logic [31:0] wd, input logic [31:0] exp_d, input bit exp_e,
                     input bit chk_d, input string tag);
    item_t it;
    @(negedge clk);
    en_f = (tgt == 0); en_l = (tgt == 1); en_n = (tgt == 2);
    wr_i = wr; ext_i = ext; sel_i = sel; wd_i = wd;
    it.tgt = tgt; it.exp_d = exp_d; it.exp_e = exp_e; it.chk_d = chk_d; it.tag = tag;
    sb.push_back(it);
    pend = 1'b1;
  endtask

  task automatic wr(input int tgt, input logic [2:0] sel, input logic [31:0] wd, input string tag);
    acc(tgt, 1'b1, 1'b0, sel, wd, 32'd0, 1'b0, 1'b0, tag);
  endtask

  task automatic rd(input int tgt, input logic [2:0] sel, input logic [31:0] exp_d, input string tag);
    acc(tgt, 1'b0, 1'b0, sel, 32'd0, exp_d, 1'b0, 1'b1, tag);
  endtask

  task automatic idle();
    @(negedge clk);
    en_f = 1'b0; en_l = 1'b0; en_n = 1'b0; wr_i = 1'b0; ext_i = 1'b0;
    sel_i = '0; wd_i = '0;
    pend = 1'b0;
  endtask

  // Monitor: samples a quarter period after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #(TCLK/4);
      if (pend && sb.size() > 0) begin
        item_t it;
        logic [31:0] d;
        logic        e;
        it = sb.pop_front();
        d = (it.tgt == 0) ? rd_f : (it.tgt == 1) ? rd_l : rd_n;
        e = (it.tgt == 0) ? err_f : (it.tgt == 1) ? err_l : err_n;
        tests++;
        if (e !== it.exp_e || (it.chk_d && d !== it.exp_d)) begin
          fails++;
          $display("FAIL %s: data=%h err=%b expected data=%h err=%b",
                   it.tag, d, e, it.exp_d, it.exp_e);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    en_f = 1'b0; en_l = 1'b0; en_n = 1'b0; wr_i = 1'b0; ext_i = 1'b0;
    sel_i = '0; wd_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(0, 3'd0, 32'd0, "R1 pid reset");
    rd(0, 3'd1, 32'd0, "R1 zone reset");
    rd(0, 3'd2, 32'd0, "R1 index reset");
    wr(0, 3'd5, 32'h0000_0000, "R1 search on empty tlb");
    rd(0, 3'd2, 32'h8000_0000, "R1 R7 empty tlb misses");

    // R14: zone register
    wr(0, 3'd1, 32'hA5A5_1234, "R14 zone write");
    rd(0, 3'd1, 32'hA5A5_1234, "R14 zone readback");

    // R3: PID keeps 8 bits
    wr(0, 3'd0, 32'h0000_012C, "R3 pid write");
    rd(0, 3'd0, 32'h0000_002C, "R3 pid 8-bit readback");

    // Entry 2: 4 KiB page at 0x0040_0000, tid 0x2C
    wr(0, 3'd2, 32'd2, "R2 index=2");
    wr(0, 3'd3, 32'h0040_00C0, "R3 hi write e2");
    acc(0, 1'b1, 1'b0, 3'd4, 32'h1111_2222, 32'd0, 1'b0, 1'b0, "R10 lo low write");
    acc(0, 1'b1, 1'b1, 3'd4, 32'h0000_00AB, 32'd0, 1'b0, 1'b0, "R10 lo ext write");
    acc(0, 1'b0, 1'b0, 3'd4, 32'd0, 32'h1111_2222, 1'b0, 1'b1, "R10 lo low half");
    acc(0, 1'b0, 1'b1, 3'd4, 32'd0, 32'h0000_00AB, 1'b0, 1'b1, "R10 lo upper half");

    // Entry 5: 1 MiB page at 0x0080_0000, tid 0
    wr(0, 3'd2, 32'd5, "R2 index=5");
    wr(0, 3'd0, 32'd0, "R3 pid=0");
    wr(0, 3'd3, 32'h0080_02C0, "R3 hi write e5");
    wr(0, 3'd4, 32'h0000_3333, "R2 lo write e5");

    // R4: HI read loads PID
    wr(0, 3'd2, 32'd2, "R2 index=2");
    rd(0, 3'd3, 32'h0040_00C0, "R4 hi read e2");
    rd(0, 3'd0, 32'h0000_002C, "R4 pid from tid e2");
    rd(0, 3'd4, 32'h1111_2222, "R2 lo of e2");
    wr(0, 3'd2, 32'd5, "R2 index=5");
    rd(0, 3'd4, 32'h0000_3333, "R2 lo of e5");
    rd(0, 3'd0, 32'h0000_002C, "R4 pid unchanged by lo read");

    // Searches with PID 0x2C
    wr(0, 3'd5, 32'h0040_0ABC, "R6 search e2");
    rd(0, 3'd2, 32'h0000_0002, "R6 hit e2");
    wr(0, 3'd5, 32'h008F_1234, "R8 search inside 1MiB");
    rd(0, 3'd2, 32'h0000_0005, "R8 R9 hit e5 tid0");
    wr(0, 3'd5, 32'h0090_0000, "R8 search past 1MiB");
    rd(0, 3'd2, 32'h8000_0000, "R7 R8 miss past page");
    wr(0, 3'd5, 32'h0040_1000, "R8 search past 4KiB");
    rd(0, 3'd2, 32'h8000_0000, "R8 miss next 4KiB page");

    // R9: translation ID mismatch
    wr(0, 3'd0, 32'h0000_0011, "R9 pid=0x11");
    wr(0, 3'd5, 32'h0040_0000, "R9 search e2 wrong pid");
    rd(0, 3'd2, 32'h8000_0000, "R9 tid mismatch miss");

    // R5: miss flag is read-only
    wr(0, 3'd2, 32'h0000_0009, "R5 index write with flag set");
    rd(0, 3'd2, 32'h8000_0009, "R5 flag kept set");

    // R6 priority: entry 9 overlaps entry 5
    wr(0, 3'd0, 32'd0, "R6 pid=0");
    wr(0, 3'd3, 32'h0080_00C0, "R6 hi write e9");
    wr(0, 3'd5, 32'h0080_0010, "R6 search overlap");
    rd(0, 3'd2, 32'h0000_0005, "R6 lowest index wins");

    wr(0, 3'd2, 32'hFFFF_FFF3, "R5 index write flag clear");
    rd(0, 3'd2, 32'h7FFF_FFF3, "R5 flag kept clear");
    rd(0, 3'd3, 32'h0000_0000, "R2 upper index bits ignored, e3 empty");
    rd(0, 3'd0, 32'h0000_0000, "R4 pid from e3 tid");

    // Illegal accesses
    acc(0, 1'b0, 1'b0, 3'd5, 32'd0, 32'd0, 1'b1, 1'b1, "R11 search read");
    acc(0, 1'b0, 1'b1, 3'd3, 32'd0, 32'd0, 1'b1, 1'b1, "R10 ext hi read");
    acc(0, 1'b1, 1'b1, 3'd0, 32'h55, 32'd0, 1'b1, 1'b0, "R10 ext pid write");
    rd(0, 3'd0, 32'h0000_0000, "R10 pid unchanged");
    acc(0, 1'b1, 1'b0, 3'd6, 32'h1234, 32'd0, 1'b1, 1'b0, "R13 sel6 write");
    acc(0, 1'b0, 1'b0, 3'd7, 32'd0, 32'd0, 1'b1, 1'b1, "R13 sel7 read");
    rd(0, 3'd1, 32'hA5A5_1234, "R13 zone unchanged");
    rd(0, 3'd2, 32'h7FFF_FFF3, "R13 index unchanged");

    // R12: limited configuration
    acc(1, 1'b1, 1'b0, 3'd0, 32'h33, 32'd0, 1'b1, 1'b0, "R12 lim pid write");
    rd(1, 3'd0, 32'd0, "R12 lim pid unchanged");
    acc(1, 1'b1, 1'b0, 3'd1, 32'hFFFF, 32'd0, 1'b1, 1'b0, "R12 lim zone write");
    rd(1, 3'd1, 32'd0, "R12 lim zone unchanged");
    acc(1, 1'b1, 1'b0, 3'd5, 32'h0, 32'd0, 1'b1, 1'b0, "R12 lim search write");
    rd(1, 3'd2, 32'd0, "R12 lim index unchanged");
    wr(1, 3'd2, 32'd4, "R12 lim index write");
    rd(1, 3'd2, 32'd4, "R12 lim index readback");
    wr(1, 3'd3, 32'h1000_00C0, "R12 lim hi write");
    rd(1, 3'd3, 32'h1000_00C0, "R12 lim hi readback");

    // R12: no TLB-capable unit
    acc(2, 1'b0, 1'b0, 3'd0, 32'd0, 32'd0, 1'b1, 1'b1, "R12 none pid read");
    acc(2, 1'b1, 1'b0, 3'd2, 32'd7, 32'd0, 1'b1, 1'b0, "R12 none index write");
    acc(2, 1'b0, 1'b0, 3'd2, 32'd0, 32'd0, 1'b1, 1'b1, "R12 none index read");

    idle();
    idle();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule